// File: doc/BRIEF.md
# Strided Banked Vector Load Unit

This block performs one vector load. A start pulse captures a base word address, a signed stride and an element count. The block then walks the elements in order, forming each element's word address from the base plus the element index times the stride. Each address goes to an interleaved word memory that lives inside the block. That memory is split into independent banks, each with a fixed busy window and a fixed read latency. Returned words land in a vector register buffer at the slot of their element index, and a one-hot write strobe marks each landing.

Only one request leaves per cycle, and requests never overtake one another. When the next element maps to a bank that is still busy, issue waits. A stride that keeps returning to one bank therefore slows the load to one element per busy window, while a unit stride spreads the load over all banks and runs at one element per cycle. A done flag marks the end of the load. It is meant for a vector pipeline that needs a timing-faithful load path without an external memory model.

Top module: `vsl_top`

## Requirements
- R1: Element i is read from word address (base + i*stride) mod 2^16, where the stride is a 16-bit two's-complement value, so negative strides and address wrap-around are legal.
- R2: The memory word at address a holds {a XOR 16'h5A5A, a} (32 bits). Element i's word appears in vreg_q[i*32 +: 32].
- R3: There are 16 banks, selected by address bits [3:0]. A bank that accepts a request accepts no other request for the next 3 cycles, so its accepts are at least 4 cycles apart.
- R4: Requests are accepted strictly in element order, and issue stalls while the next element's bank is busy. With a stride of 0 or 16, done rises 4*VL+10 cycles after the start edge. With a stride of 8 and VL=4, it rises after 19 cycles.
- R5: Read data is written into the register buffer 12 cycles after its request is accepted. With a conflict-free stride, done rises VL+13 cycles after the start edge.
- R6: wr_stb[i] pulses for exactly one cycle per element i < VL, in the cycle the slot updates, and wr_stb is never more than one-hot. Slots at or above VL keep their previous contents.
- R7: done goes low on an accepted start. It rises one cycle after the last element's write and holds until the next accepted start. With VL=0, done rises 2 cycles after the start edge.
- R8: A start pulse that arrives while a load is in progress is ignored. The running load's timing and data are unchanged.
- R9: A VL above 16 (the buffer depth) is treated as 16.
- R10: After reset, done is 0, wr_stb is 0 and every buffer slot is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (taken only when idle) |
| base | input | 16 | Word address of element 0 |
| stride | input | 16 | Signed element stride in words |
| vl | input | 5 | Number of elements to load |
| done | output | 1 | Load finished, held until next start |
| wr_stb | output | 16 | One-hot write strobe per buffer slot |
| vreg_q | output | 512 | Register buffer contents, slot i at bits i*32 +: 32 |

## Verification
The hardest case to reach from the ports is the partial bank conflict. Elements alternate between two banks, so issue runs and stalls in turn instead of stalling on every element or never stalling. A stride of 8 produces exactly this pattern, and the bench checks the exact finish cycle against the pattern of issue edges worked out by hand. A start pulse injected mid-load and a short load that follows a full one show that ignored requests and unwritten slots leave no trace in the outputs.

// File: rtl/vsl_pkg.sv
package vsl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } vsl_state_e;

  localparam logic [15:0] WORD_SALT = 16'h5A5A;
endpackage

// File: rtl/vsl_addr_gen.sv
module vsl_addr_gen
  import vsl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MAX_VL    = 16,
  parameter int NUM_BANKS = 16,
  localparam int IDX_W  = $clog2(MAX_VL),
  localparam int VL_W   = $clog2(MAX_VL + 1),
  localparam int BSEL_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [NUM_BANKS-1:0] bank_busy_i,
  input  logic              wb_last_i,
  output logic              start_acc_o,
  output logic              zero_fin_o,
  output logic              accept_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [BSEL_W-1:0] req_bank_o,
  output logic [IDX_W-1:0]  req_idx_o,
  output logic              req_last_o
);
  vsl_state_e        state_q;
  logic [ADDR_W-1:0] base_q, stride_q, addr_q;
  logic [VL_W-1:0]   vl_q, vl_clamped;
  logic [IDX_W-1:0]  idx_q;
  logic              zero_q;

  assign vl_clamped  = (vl_i > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_i;
  assign start_acc_o = start_i && (state_q == ST_IDLE);
  assign req_addr_o  = addr_q;
  assign req_bank_o  = addr_q[BSEL_W-1:0];
  assign req_idx_o   = idx_q;
  assign req_last_o  = (VL_W'(idx_q) == vl_q - VL_W'(1));
  assign accept_o    = (state_q == ST_ISSUE) && !bank_busy_i[req_bank_o];
  assign zero_fin_o  = zero_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      stride_q <= '0;
      addr_q   <= '0;
      vl_q     <= '0;
      idx_q    <= '0;
      zero_q   <= 1'b0;
    end else begin
      zero_q <= start_acc_o && (vl_clamped == '0);
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          base_q   <= base_i;
          stride_q <= stride_i;
          addr_q   <= base_i;
          vl_q     <= vl_clamped;
          idx_q    <= '0;
          if (vl_clamped != '0) state_q <= ST_ISSUE;
        end
        ST_ISSUE: if (accept_o) begin
          addr_q <= addr_q + stride_q;
          idx_q  <= idx_q + IDX_W'(1);
          if (req_last_o) state_q <= ST_DRAIN;
        end
        ST_DRAIN: if (wb_last_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: the running address equals base + idx*stride, wrapped
  a_r1_addr_formula: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> (addr_q == base_q + ADDR_W'(idx_q) * stride_q));

  // R4: accepted element indices advance by one
  a_r4_in_order: assert property (@(posedge clk) disable iff (rst)
    (accept_o && !req_last_o) |=> (32'(idx_q) == 32'($past(idx_q)) + 1));

  // R8: a start during a load leaves the captured parameters alone
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (start_i && state_q != ST_IDLE) |=> (base_q == $past(base_q) && stride_q == $past(stride_q)));
endmodule

// File: rtl/vsl_bank_array.sv
module vsl_bank_array
  import vsl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_BANKS = 16,
  parameter int BANK_BUSY = 4,
  localparam int DATA_W = 2 * ADDR_W,
  localparam int BSEL_W = $clog2(NUM_BANKS),
  localparam int CNT_W  = $clog2(BANK_BUSY + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BSEL_W-1:0]    bank_i,
  output logic [NUM_BANKS-1:0] busy_o,
  output logic [DATA_W-1:0]    rdata_o
);
  logic [DATA_W-1:0] rdata_q [NUM_BANKS];
  logic [BSEL_W-1:0] sel_q;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    assign hit       = accept_i && (bank_i == BSEL_W'(g));
    assign busy_o[g] = (cnt_q != '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q      <= '0;
        rdata_q[g] <= '0;
      end else begin
        if (hit) begin
          cnt_q      <= CNT_W'(BANK_BUSY - 1);
          rdata_q[g] <= {addr_i ^ ADDR_W'(WORD_SALT), addr_i};
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end

    // R3: a bank never takes a request during its busy window
    a_r3_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
      hit |-> (cnt_q == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (accept_i) sel_q <= bank_i;
  end

  assign rdata_o = rdata_q[sel_q];
endmodule

// File: rtl/vsl_return_pipe.sv
module vsl_return_pipe #(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 4,
  parameter int MEM_LAT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] bank_data_i,
  output logic              wb_valid_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic              wb_last_o,
  output logic [DATA_W-1:0] wb_data_o
);
  logic              v_q    [MEM_LAT];
  logic [IDX_W-1:0]  idx_q  [MEM_LAT];
  logic              last_q [MEM_LAT];
  logic [DATA_W-1:0] data_q [MEM_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q[0]    <= 1'b0;
      idx_q[0]  <= '0;
      last_q[0] <= 1'b0;
    end else begin
      v_q[0]    <= accept_i;
      idx_q[0]  <= idx_i;
      last_q[0] <= accept_i && last_i;
    end
  end
  // stage 0 data is held inside the bank that was read
  assign data_q[0] = bank_data_i;

  for (genvar k = 1; k < MEM_LAT; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q[k]    <= 1'b0;
        idx_q[k]  <= '0;
        last_q[k] <= 1'b0;
        data_q[k] <= '0;
      end else begin
        v_q[k]    <= v_q[k-1];
        idx_q[k]  <= idx_q[k-1];
        last_q[k] <= last_q[k-1];
        data_q[k] <= data_q[k-1];
      end
    end
  end

  assign wb_valid_o = v_q[MEM_LAT-1];
  assign wb_idx_o   = idx_q[MEM_LAT-1];
  assign wb_last_o  = v_q[MEM_LAT-1] && last_q[MEM_LAT-1];
  assign wb_data_o  = data_q[MEM_LAT-1];
endmodule

// File: rtl/vsl_vreg.sv
module vsl_vreg #(
  parameter int DATA_W = 32,
  parameter int MAX_VL = 16,
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_acc_i,
  input  logic                     zero_fin_i,
  input  logic                     wb_valid_i,
  input  logic [IDX_W-1:0]         wb_idx_i,
  input  logic                     wb_last_i,
  input  logic [DATA_W-1:0]        wb_data_i,
  output logic                     done_o,
  output logic [MAX_VL-1:0]        wr_stb_o,
  output logic [MAX_VL*DATA_W-1:0] vreg_o
);
  logic [DATA_W-1:0] elem_q [MAX_VL];
  logic [MAX_VL-1:0] stb_q;
  logic              fin_q, done_q;

  for (genvar e = 0; e < MAX_VL; e++) begin : g_elem
    always_ff @(posedge clk) begin
      if (rst) elem_q[e] <= '0;
      else if (wb_valid_i && wb_idx_i == IDX_W'(e)) elem_q[e] <= wb_data_i;
    end
    assign vreg_o[e*DATA_W +: DATA_W] = elem_q[e];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q  <= '0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      stb_q <= wb_valid_i ? (MAX_VL'(1) << wb_idx_i) : '0;
      fin_q <= wb_last_i || zero_fin_i;
      if (start_acc_i)  done_q <= 1'b0;
      else if (fin_q)   done_q <= 1'b1;
    end
  end

  assign wr_stb_o = stb_q;
  assign done_o   = done_q;

  // R6: at most one slot is written per cycle
  a_r6_stb_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb_q));

  // R7: done only rises after a finishing write-back or an empty load
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
    (wb_last_i && !start_acc_i) |=> ##1 done_q);
endmodule

// File: rtl/vsl_top.sv
module vsl_top #(
  parameter int ADDR_W    = 16,
  parameter int MAX_VL    = 16,
  parameter int NUM_BANKS = 16,
  parameter int BANK_BUSY = 4,
  parameter int MEM_LAT   = 12,
  localparam int DATA_W = 2 * ADDR_W,
  localparam int IDX_W  = $clog2(MAX_VL),
  localparam int VL_W   = $clog2(MAX_VL + 1),
  localparam int BSEL_W = $clog2(NUM_BANKS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        base,
  input  logic [ADDR_W-1:0]        stride,
  input  logic [VL_W-1:0]          vl,
  output logic                     done,
  output logic [MAX_VL-1:0]        wr_stb,
  output logic [MAX_VL*DATA_W-1:0] vreg_q
);
  logic                 start_acc, zero_fin, accept, req_last;
  logic [ADDR_W-1:0]    req_addr;
  logic [BSEL_W-1:0]    req_bank;
  logic [IDX_W-1:0]     req_idx;
  logic [NUM_BANKS-1:0] bank_busy;
  logic [DATA_W-1:0]    bank_data, wb_data;
  logic                 wb_valid, wb_last;
  logic [IDX_W-1:0]     wb_idx;

  vsl_addr_gen #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL), .NUM_BANKS(NUM_BANKS)) u_agen (
    .clk(clk), .rst(rst), .start_i(start), .base_i(base), .stride_i(stride),
    .vl_i(vl), .bank_busy_i(bank_busy), .wb_last_i(wb_last),
    .start_acc_o(start_acc), .zero_fin_o(zero_fin), .accept_o(accept),
    .req_addr_o(req_addr), .req_bank_o(req_bank), .req_idx_o(req_idx),
    .req_last_o(req_last));

  vsl_bank_array #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_BUSY(BANK_BUSY)) u_banks (
    .clk(clk), .rst(rst), .accept_i(accept), .addr_i(req_addr), .bank_i(req_bank),
    .busy_o(bank_busy), .rdata_o(bank_data));

  vsl_return_pipe #(.DATA_W(DATA_W), .IDX_W(IDX_W), .MEM_LAT(MEM_LAT)) u_pipe (
    .clk(clk), .rst(rst), .accept_i(accept), .idx_i(req_idx), .last_i(req_last),
    .bank_data_i(bank_data), .wb_valid_o(wb_valid), .wb_idx_o(wb_idx),
    .wb_last_o(wb_last), .wb_data_o(wb_data));

  vsl_vreg #(.DATA_W(DATA_W), .MAX_VL(MAX_VL)) u_vreg (
    .clk(clk), .rst(rst), .start_acc_i(start_acc), .zero_fin_i(zero_fin),
    .wb_valid_i(wb_valid), .wb_idx_i(wb_idx), .wb_last_i(wb_last),
    .wb_data_i(wb_data), .done_o(done), .wr_stb_o(wr_stb), .vreg_o(vreg_q));
endmodule

// File: tb/vsl_top_tb_top.sv
module vsl_top_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [15:0]  base = '0;
  logic [15:0]  stride = '0;
  logic [4:0]   vl = '0;
  logic         done;
  logic [15:0]  wr_stb;
  logic [511:0] vreg_q;

  int n_chk = 0;
  int n_bad = 0;
  int stb_cnt [16];
  int cyc = 0;

  always #4 clk = ~clk;

  vsl_top dut_i (.clk(clk), .rst(rst), .start(start), .base(base), .stride(stride),
                 .vl(vl), .done(done), .wr_stb(wr_stb), .vreg_q(vreg_q));

  always @(negedge clk)
    for (int i = 0; i < 16; i++) if (wr_stb[i]) stb_cnt[i]++;

  function automatic logic [31:0] mem_word(input logic [15:0] a);
    return {a ^ 16'h5A5A, a};
  endfunction

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      summary_and_end();
    end
  end

  // Launch a load, optionally inject an extra start, and return edges until done.
  task automatic launch(input logic [15:0] b, input logic [15:0] s, input logic [4:0] n,
                        input int inject_at, output int edges);
    for (int i = 0; i < 16; i++) stb_cnt[i] = 0;
    @(negedge clk);
    base = b; stride = s; vl = n; start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    edges = 0;
    while (edges < 400) begin
      @(negedge clk);
      if (edges + 1 == inject_at) begin
        base = 16'hBEEF; stride = 16'h0003; vl = 5'd2; start = 1'b1;
      end else start = 1'b0;
      @(posedge clk);
      edges++;
      #1;
      if (done) break;
    end
    @(negedge clk) start = 1'b0;
  endtask

  task automatic check_data(input string req, input logic [15:0] b, input logic [15:0] s,
                            input int n, input logic [511:0] prior);
    logic [511:0] exp;
    exp = prior;
    for (int i = 0; i < n; i++) exp[i*32 +: 32] = mem_word(b + 16'(i) * s);
    check(req, vreg_q, exp);
    for (int i = 0; i < 16; i++)
      check({req, " R6 strobe"}, 512'(stb_cnt[i]), 512'(i < n ? 1 : 0));
  endtask

  task automatic t_reset();
    check("R10 done", 512'(done), 512'(0));
    check("R10 wr_stb", 512'(wr_stb), 512'(0));
    check("R10 vreg", vreg_q, 512'(0));
  endtask

  task automatic t_unit_stride();
    int e;
    logic [511:0] prior;
    prior = vreg_q;
    launch(16'h0100, 16'h0001, 5'd16, -1, e);
    check("R5 unit stride finish", 512'(e), 512'(29));
    check_data("R1 R2 unit stride", 16'h0100, 16'h0001, 16, prior);
  endtask

  task automatic t_single_bank();
    int e;
    logic [511:0] prior;
    prior = vreg_q;
    launch(16'h0040, 16'h0000, 5'd5, -1, e);
    check("R4 stride 0 finish", 512'(e), 512'(30));
    check_data("R4 stride 0 data", 16'h0040, 16'h0000, 5, prior);
    prior = vreg_q;
    launch(16'h0207, 16'h0010, 5'd3, -1, e);
    check("R3 stride 16 finish", 512'(e), 512'(22));
    check_data("R3 stride 16 data", 16'h0207, 16'h0010, 3, prior);
  endtask

  task automatic t_two_bank();
    int e;
    logic [511:0] prior;
    prior = vreg_q;
    launch(16'h0300, 16'h0008, 5'd4, -1, e);
    check("R4 stride 8 finish", 512'(e), 512'(19));
    check_data("R4 stride 8 data", 16'h0300, 16'h0008, 4, prior);
    prior = vreg_q;
    launch(16'h0000, 16'h0002, 5'd16, -1, e);
    check("R5 stride 2 finish", 512'(e), 512'(29));
    check_data("R5 stride 2 data", 16'h0000, 16'h0002, 16, prior);
  endtask

  task automatic t_negative_wrap();
    int e;
    logic [511:0] prior;
    prior = vreg_q;
    launch(16'h0003, 16'hFFFF, 5'd6, -1, e);
    check("R1 negative stride finish", 512'(e), 512'(19));
    check_data("R1 negative stride wrap", 16'h0003, 16'hFFFF, 6, prior);
  endtask

  task automatic t_ignore_start();
    int e;
    logic [511:0] prior;
    prior = vreg_q;
    launch(16'h0500, 16'h0001, 5'd8, 3, e);
    check("R8 ignored start finish", 512'(e), 512'(21));
    check_data("R8 ignored start data", 16'h0500, 16'h0001, 8, prior);
  endtask

  task automatic t_short_and_zero();
    int e;
    logic [511:0] prior;
    launch(16'h0700, 16'h0001, 5'd16, -1, e);
    prior = vreg_q;
    launch(16'h0900, 16'h0001, 5'd4, -1, e);
    check("R6 short finish", 512'(e), 512'(17));
    check_data("R6 upper slots untouched", 16'h0900, 16'h0001, 4, prior);
    prior = vreg_q;
    launch(16'h0A00, 16'h0001, 5'd0, -1, e);
    check("R7 zero length finish", 512'(e), 512'(2));
    check_data("R7 zero length no writes", 16'h0A00, 16'h0001, 0, prior);
  endtask

  task automatic t_clamp();
    int e;
    logic [511:0] prior;
    prior = vreg_q;
    launch(16'h0C00, 16'h0001, 5'd20, -1, e);
    check("R9 clamp finish", 512'(e), 512'(29));
    check_data("R9 clamp data", 16'h0C00, 16'h0001, 16, prior);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R7 done cleared on start", 512'(done), 512'(0));
    repeat (40) @(negedge clk);
    check("R7 done held", 512'(done), 512'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unit_stride();
    t_single_bank();
    t_two_bank();
    t_negative_wrap();
    t_ignore_start();
    t_short_and_zero();
    t_clamp();
    summary_and_end();
  end
endmodule